// File: doc/BRIEF.md
# Signed Baugh-Wooley Array Multiplier

This block multiplies two two's-complement operands of `WIDTH` bits and returns the full signed product of `2*WIDTH` bits. It is purely combinational. There is no clock, no register and no handshake, so the product follows the operands within the same cycle. It is meant to sit inside a datapath stage whose own registers capture the result.

A plain unsigned array gives wrong double-width results for negative operands. The obvious fix is to sign-extend both operands, but that needs an array twice as wide and twice as tall. This design keeps a `WIDTH x WIDTH` grid instead. A partial-product bit is inverted when exactly one of its two factor bits is a sign bit, and the product of the two sign bits stays uninverted.

Two constant ones then correct the sum. One sits at weight `2^WIDTH` and the other at weight `2^(2*WIDTH-1)`. Both use adder inputs that would otherwise be tied low: the top carry input of the first adder row, and the spare top input of the closing ripple row. The grid has one full-adder row per multiplier bit. Each row hands its lowest sum bit straight out as a product bit, and a final ripple-carry row resolves the upper half of the product.

Top module: `sbw_signed_mult`

## Requirements
- R1: For every operand pair, `prod` equals the two's-complement product of `x_in` and `y_in`, both read as signed, written in 2*WIDTH bits.
- R2: With x_in = 4'b1110 (-2) and y_in = 4'b0011 (3), `prod` is 8'hFA (-6).
- R3: The square of the most negative operand is positive: x_in = y_in = 4'b1000 gives 8'h40 (+64).
- R4: The most negative product is exact: (-8) x 7 and 7 x (-8) both give 8'hC8 (-56).
- R5: If either operand is zero, `prod` is all zeros.
- R6: The low WIDTH bits of `prod` equal the low WIDTH bits of the unsigned product of the raw operand bit patterns.
- R7: Swapping the two operands leaves `prod` unchanged.
- R8: `prod` reflects new operand values without any clock edge.
- R9: Multiplying by +1 returns the other operand sign-extended to 2*WIDTH bits. Multiplying by -1 (all ones) returns its negation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_in | input | WIDTH | Multiplicand, two's complement |
| y_in | input | WIDTH | Multiplier, two's complement; selects one adder row per bit |
| prod | output | 2*WIDTH | Signed product |

## Verification
A faulty cell or a misplaced correction bit corrupts `prod` at once, with no delay. The bench samples one nanosecond after the operands change, so the error is seen on the same vector.

Each fault class has its own signature:
- An inversion on the wrong partial-product bit only shows up when the sign bit involved is set.
- A lost correction constant shifts every product by `2^WIDTH` or `2^(2*WIDTH-1)`.
- A broken carry link only shows on operand pairs that carry through that cell.

For that reason the bench covers all operand pairs rather than a sample.

// File: rtl/sbw_pkg.sv
package sbw_pkg;

  // Outputs of one full-adder cell.
  typedef struct packed {
    logic sum;
    logic carry;
  } fa_out_t;

  // A partial-product bit is inverted when exactly one of its
  // factors is a sign bit (top row or top column of the grid).
  function automatic logic pp_inverted(input int row, input int col, input int width);
    return logic'((row == width - 1) ^ (col == width - 1));
  endfunction

endpackage

// File: rtl/sbw_fa_cell.sv
module sbw_fa_cell
  import sbw_pkg::*;
(
  input  logic    a_i,
  input  logic    b_i,
  input  logic    c_i,
  output fa_out_t res_o
);
  assign res_o.sum   = a_i ^ b_i ^ c_i;
  assign res_o.carry = (a_i & b_i) | (b_i & c_i) | (a_i & c_i);
endmodule

// File: rtl/sbw_pp_gen.sv
module sbw_pp_gen
  import sbw_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0]       x_in,
  input  logic [WIDTH-1:0]       y_in,
  output logic [WIDTH*WIDTH-1:0] pp_flat
);
  // pp_flat[r*WIDTH + c] has weight 2^(r+c): row r uses y_in[r], column c uses x_in[c].
  for (genvar r = 0; r < WIDTH; r++) begin : g_r
    for (genvar c = 0; c < WIDTH; c++) begin : g_c
      assign pp_flat[r*WIDTH + c] = (x_in[c] & y_in[r]) ^ pp_inverted(r, c, WIDTH);
    end
  end

  // R1: with a non-negative multiplier, the inverted part of the sign row is all ones.
  always_comb begin
    if (!y_in[WIDTH-1]) begin
      a_r1_sign_row_band: assert (&pp_flat[(WIDTH-1)*WIDTH +: WIDTH-1])
        else $error("sign row band not all ones");
    end
  end
endmodule

// File: rtl/sbw_csa_row.sv
module sbw_csa_row
  import sbw_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic [WIDTH-1:0] c_in,
  output logic [WIDTH-1:0] sum_o,
  output logic [WIDTH-1:0] carry_o
);
  localparam int EW = WIDTH + 2;

  for (genvar k = 0; k < WIDTH; k++) begin : g_cell
    fa_out_t r;
    sbw_fa_cell u_fa (.a_i(a_in[k]), .b_i(b_in[k]), .c_i(c_in[k]), .res_o(r));
    assign sum_o[k]   = r.sum;
    assign carry_o[k] = r.carry;
  end

  // R1: the row preserves the arithmetic value of its three inputs.
  always_comb begin
    a_r1_row_conserves: assert (EW'(a_in) + EW'(b_in) + EW'(c_in) ==
                                EW'(sum_o) + {1'b0, carry_o, 1'b0})
      else $error("carry-save row lost value");
  end
endmodule

// File: rtl/sbw_ripple_add.sv
module sbw_ripple_add
  import sbw_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] sum_o
);
  for (genvar k = 0; k < WIDTH; k++) begin : g_bit
    fa_out_t r;
    logic    ci;
    if (k == 0) begin : g_lsb
      assign ci = 1'b0;
    end else begin : g_up
      assign ci = g_bit[k-1].r.carry;
    end
    sbw_fa_cell u_fa (.a_i(a_in[k]), .b_i(b_in[k]), .c_i(ci), .res_o(r));
    assign sum_o[k] = r.sum;
  end

  // R1: the ripple chain yields the true sum of its two inputs.
  always_comb begin
    a_r1_ripple_sum: assert ({1'b0, a_in} + {1'b0, b_in} == {g_bit[WIDTH-1].r.carry, sum_o})
      else $error("ripple row sum wrong");
  end
endmodule

// File: rtl/sbw_signed_mult.sv
module sbw_signed_mult
  import sbw_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0]   x_in,
  input  logic [WIDTH-1:0]   y_in,
  output logic [2*WIDTH-1:0] prod
);
  localparam int PW = 2 * WIDTH;

  logic [WIDTH*WIDTH-1:0] pp_flat;

  sbw_pp_gen #(.WIDTH(WIDTH)) u_pp (.x_in(x_in), .y_in(y_in), .pp_flat(pp_flat));

  // Row r: sum bit k has weight 2^(r+k), carry bit k has weight 2^(r+k+1).
  for (genvar r = 0; r < WIDTH; r++) begin : g_row
    logic [WIDTH-1:0] s;
    logic [WIDTH-1:0] c;
    if (r == 0) begin : g_first
      assign s = pp_flat[WIDTH-1:0];
      // Correction constant of weight 2^WIDTH rides on a spare carry slot.
      assign c = {1'b1, {(WIDTH-1){1'b0}}};
    end else begin : g_add
      logic [WIDTH-1:0] b_sh;
      assign b_sh = {1'b0, g_row[r-1].s[WIDTH-1:1]};
      sbw_csa_row #(.WIDTH(WIDTH)) u_row (
        .a_in   (pp_flat[r*WIDTH +: WIDTH]),
        .b_in   (b_sh),
        .c_in   (g_row[r-1].c),
        .sum_o  (s),
        .carry_o(c)
      );
    end
    assign prod[r] = s[0];
  end

  // Closing ripple row; its spare top input carries the 2^(PW-1) correction.
  logic [WIDTH-1:0] fin_a;
  assign fin_a = {1'b1, g_row[WIDTH-1].s[WIDTH-1:1]};

  sbw_ripple_add #(.WIDTH(WIDTH)) u_fin (
    .a_in (fin_a),
    .b_in (g_row[WIDTH-1].c),
    .sum_o(prod[PW-1:WIDTH])
  );

  // Port-level checks.
  logic signed [PW-1:0] xs_ref, ys_ref, p_ref;
  logic        [WIDTH-1:0] lo_ref;
  always_comb begin
    xs_ref = PW'($signed(x_in));
    ys_ref = PW'($signed(y_in));
    p_ref  = xs_ref * ys_ref;
    lo_ref = x_in * y_in;
    a_r1_signed_product: assert (prod == p_ref)
      else $error("product differs from signed reference");
    a_r6_low_half: assert (prod[WIDTH-1:0] == lo_ref)
      else $error("low half differs from unsigned low half");
    if (x_in == '0 || y_in == '0) begin
      a_r5_zero_operand: assert (prod == '0)
        else $error("zero operand gave nonzero product");
    end
  end
endmodule

// File: tb/sbw_signed_mult_tb.sv
module sbw_signed_mult_tb_top;
  localparam int W  = 4;
  localparam int PW = 2 * W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [W-1:0]  x_in = '0;
  logic [W-1:0]  y_in = '0;
  logic [PW-1:0] prod;

  sbw_signed_mult #(.WIDTH(W)) dut_i (.x_in(x_in), .y_in(y_in), .prod(prod));

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  // Vector: {x, y, expected product}
  localparam int NV = 15;
  localparam logic [15:0] VEC [NV] = '{
    {4'b1110, 4'b0011, 8'hFA},  // R2 -2*3
    {4'b1000, 4'b1000, 8'h40},  // R3
    {4'b1000, 4'b0111, 8'hC8},  // R4
    {4'b0111, 4'b1000, 8'hC8},  // R4
    {4'b0111, 4'b0111, 8'h31},  // R1
    {4'b1111, 4'b1111, 8'h01},  // R1
    {4'b0000, 4'b1011, 8'h00},  // R5
    {4'b0001, 4'b1010, 8'hFA},  // R9
    {4'b1111, 4'b0101, 8'hFB},  // R9
    {4'b0110, 4'b1001, 8'hD6},  // R1
    {4'b0101, 4'b0011, 8'h0F},  // R1
    {4'b1011, 4'b1101, 8'h0F},  // R1
    {4'b0101, 4'b0001, 8'h05},  // R9
    {4'b1010, 4'b1111, 8'h06},  // R9
    {4'b1000, 4'b1111, 8'h08}   // R9
  };

  task automatic check(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s x=%b y=%b actual=%h expected=%h", req, x_in, y_in, act, exp);
    end
  endtask

  // R8: operands change after a falling edge, sampled 1 ns later with no clock edge between.
  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    x_in = a;
    y_in = b;
    #1;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 20000 && !done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected<20000", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    // Reset phase: zero operands give a zero product (R5).
    repeat (3) @(posedge clk);
    #1;
    check("R5 reset zero", prod, '0);
    rst_n = 1'b1;

    // Table walk
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][15:12], VEC[i][11:8]);
      check("R2/R3/R4/R9/R8 table", prod, VEC[i][7:0]);
    end

    // Exhaustive sweep: R1, R6, R7
    for (int a = 0; a < (1 << W); a++) begin
      for (int b = 0; b < (1 << W); b++) begin
        int sa, sb;
        logic [PW-1:0] first;
        sa = (a >= (1 << (W-1))) ? a - (1 << W) : a;
        sb = (b >= (1 << (W-1))) ? b - (1 << W) : b;
        apply(W'(a), W'(b));
        first = prod;
        check("R1 signed", prod, PW'(sa * sb));
        check("R6 low half", {{W{1'b0}}, prod[W-1:0]}, {{W{1'b0}}, W'(a * b)});
        apply(W'(b), W'(a));
        check("R7 swap", prod, first);
      end
    end

    // Corner directed: zero against every value (R5), +1 and -1 (R9)
    for (int v = 0; v < (1 << W); v++) begin
      int sv;
      sv = (v >= (1 << (W-1))) ? v - (1 << W) : v;
      apply('0, W'(v));
      check("R5 zero x", prod, '0);
      apply(W'(1), W'(v));
      check("R9 times one", prod, PW'(sv));
      apply(W'(v), '1);
      check("R9 times minus one", prod, PW'(-sv));
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule